// File: doc/BRIEF.md
# PCIe Completer Request to AXI-Lite Bridge

This block sits behind a PCIe endpoint's completer interface. Each decoded request comes in as one single-beat descriptor. The block turns it into exactly one 32-bit AXI4-Lite master access. Memory reads, memory writes, IO reads and IO writes are supported, each at most one doubleword long.

Non-posted requests (both reads and IO writes) are answered with a single-beat completion descriptor. That descriptor echoes the request tag and carries a completer ID taken from a configuration input. Memory writes are posted, so they never produce a completion. Requests longer than one doubleword never reach the AXI side. An oversized memory write is dropped silently and raises the uncorrectable-error strobe. An oversized non-posted request is answered with a completer-abort completion and raises the correctable-error strobe.

Only one request is handled at a time. The request port drops ready from the cycle it accepts a request until the AXI transaction has finished and any completion has been taken.

Top module: `pcie_axil_bridge`

## Requirements
- R1: After reset, `req_ready` is 1, and `cpl_valid`, `m_awvalid`, `m_wvalid`, `m_arvalid`, `err_cor` and `err_uncor` are all 0.
- R2: A memory write (`req_kind` = 1) with `req_len` = 1 issues one AXI write. The address is the request address with bits 1:0 cleared, `m_wdata` = `req_data`, and `m_wstrb` = `req_be`. Bytes whose enable is 0 are left unchanged at the target, and no completion follows.
- R3: The AW and W handshakes may complete in either order or in the same cycle. The bridge waits for both, then for the B response, before it finishes the write.
- R4: An IO write (`req_kind` = 3) with `req_len` = 1 issues one AXI write. After an OKAY response it returns a completion with `cpl_has_data` = 0 and `cpl_status` = 0 (successful).
- R5: A memory read (`req_kind` = 0) or IO read (`req_kind` = 2) with `req_len` = 1 issues one AXI read. The completion has `cpl_has_data` = 1, `cpl_status` = 0, and `cpl_data` equal to the whole 32-bit read word, whatever the byte enables.
- R6: Every completion carries `cpl_tag` equal to the request's `req_tag`. Its `cpl_cid` equals the `cfg_cid` value present when the completion is produced.
- R7: For a non-posted request, a B or R response other than OKAY (00) gives `cpl_status` = 4 (completer abort).
- R8: A memory write with `req_len` other than 1 makes no AXI access and produces no completion. It raises `err_uncor` for exactly one cycle, and `err_cor` stays 0.
- R9: A read or IO write with `req_len` other than 1 makes no AXI access. It is answered with `cpl_status` = 4, `cpl_has_data` = 0 and the original tag, and `err_cor` is raised for one cycle.
- R10: `req_ready` is 0 from the cycle after a legal request is accepted until its AXI access and any completion are finished. It stays 1 after an oversized memory write.
- R11: While `cpl_valid` is 1 and `cpl_ready` is 0, `cpl_valid` and every completion field hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cid | input | 16 | Completer bus/device/function ID |
| req_valid | input | 1 | Request descriptor valid |
| req_ready | output | 1 | Bridge can accept a request |
| req_kind | input | 2 | 0 mem read, 1 mem write, 2 IO read, 3 IO write |
| req_addr | input | ADDR_W | Byte address of the request |
| req_len | input | LEN_W | Length in doublewords |
| req_be | input | 4 | First-doubleword byte enables |
| req_tag | input | TAG_W | Requester tag |
| req_data | input | 32 | Write payload |
| cpl_valid | output | 1 | Completion descriptor valid |
| cpl_ready | input | 1 | Completion accepted |
| cpl_tag | output | TAG_W | Echoed tag |
| cpl_status | output | 3 | 0 successful, 4 completer abort |
| cpl_has_data | output | 1 | Completion carries data |
| cpl_data | output | 32 | Read data |
| cpl_cid | output | 16 | Completer ID |
| m_awaddr | output | ADDR_W | AXI write address |
| m_awprot | output | 3 | AXI write protection (constant) |
| m_awvalid | output | 1 | AXI write address valid |
| m_awready | input | 1 | AXI write address ready |
| m_wdata | output | 32 | AXI write data |
| m_wstrb | output | 4 | AXI write strobes |
| m_wvalid | output | 1 | AXI write data valid |
| m_wready | input | 1 | AXI write data ready |
| m_bresp | input | 2 | AXI write response |
| m_bvalid | input | 1 | AXI write response valid |
| m_bready | output | 1 | AXI write response ready |
| m_araddr | output | ADDR_W | AXI read address |
| m_arprot | output | 3 | AXI read protection (constant) |
| m_arvalid | output | 1 | AXI read address valid |
| m_arready | input | 1 | AXI read address ready |
| m_rdata | input | 32 | AXI read data |
| m_rresp | input | 2 | AXI read response |
| m_rvalid | input | 1 | AXI read data valid |
| m_rready | output | 1 | AXI read data ready |
| err_cor | output | 1 | Correctable-error strobe |
| err_uncor | output | 1 | Uncorrectable-error strobe |

## Verification
Every width and offset of a sub-doubleword write is run against a target word pre-filled with a marker pattern. A bridge that wired strobes wrongly or passed an unaligned address would corrupt neighbouring bytes, or write to the wrong word. The AW and W channels are accepted early, late and together, which catches a bridge that finishes a write after only one handshake, or hangs when both arrive in one cycle. Oversized writes and reads are checked for zero AXI activity, for which strobe fires, and for the abort completion. Error responses from the target are checked to become an abort only on non-posted requests. The completion port is held stalled to catch fields or valid that do not hold, and a ready signal that returns while a request is still open.

// File: rtl/pxb_pkg.sv
package pxb_pkg;
  typedef enum logic [1:0] {
    REQ_MEM_RD = 2'd0,
    REQ_MEM_WR = 2'd1,
    REQ_IO_RD  = 2'd2,
    REQ_IO_WR  = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WRITE,
    ST_BRESP,
    ST_RADDR,
    ST_RDATA,
    ST_CPL
  } ctrl_state_e;

  localparam logic [2:0] CPL_SC = 3'b000;
  localparam logic [2:0] CPL_CA = 3'b100;
  localparam logic [1:0] AXRESP_OKAY = 2'b00;
endpackage

// File: rtl/pxb_decode.sv
module pxb_decode #(
  parameter int LEN_W = 11
) (
  input  logic [1:0]       kind,
  input  logic [LEN_W-1:0] len,
  output logic             is_write,
  output logic             is_posted,
  output logic             single_dw
);
  import pxb_pkg::*;

  localparam logic [LEN_W-1:0] ONE_DW = LEN_W'(1);

  always_comb begin
    is_write  = (kind == REQ_MEM_WR) || (kind == REQ_IO_WR);
    is_posted = (kind == REQ_MEM_WR);
    single_dw = (len == ONE_DW);
  end
endmodule

// File: rtl/pxb_cpl_out.sv
module pxb_cpl_out #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [TAG_W-1:0] ld_tag,
  input  logic [2:0]       ld_status,
  input  logic             ld_has_data,
  input  logic [31:0]      ld_data,
  input  logic [15:0]      cfg_cid,
  input  logic             cpl_ready,
  output logic             cpl_valid,
  output logic [TAG_W-1:0] cpl_tag,
  output logic [2:0]       cpl_status,
  output logic             cpl_has_data,
  output logic [31:0]      cpl_data,
  output logic [15:0]      cpl_cid,
  output logic             cpl_done
);
  logic             valid_d;
  logic             fld_en;

  assign cpl_done = cpl_valid && cpl_ready;

  always_comb begin
    fld_en  = load;
    valid_d = cpl_valid;
    if (cpl_done) valid_d = 1'b0;
    if (load)     valid_d = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cpl_valid <= 1'b0;
    else        cpl_valid <= valid_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cpl_tag      <= '0;
      cpl_status   <= '0;
      cpl_has_data <= 1'b0;
      cpl_data     <= '0;
      cpl_cid      <= '0;
    end else if (fld_en) begin
      cpl_tag      <= ld_tag;
      cpl_status   <= ld_status;
      cpl_has_data <= ld_has_data;
      cpl_data     <= ld_data;
      cpl_cid      <= cfg_cid;
    end
  end

  assert_cpl_hold_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (cpl_valid && !cpl_ready) |=> (cpl_valid && $stable(cpl_tag) && $stable(cpl_status)
      && $stable(cpl_data) && $stable(cpl_has_data) && $stable(cpl_cid)));
endmodule

// File: rtl/pxb_ctrl.sv
module pxb_ctrl #(
  parameter int         ADDR_W = 32,
  parameter int         TAG_W  = 8,
  parameter logic [2:0] PROT   = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [3:0]        req_be,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [31:0]       req_data,
  input  logic              dec_write,
  input  logic              dec_posted,
  input  logic              dec_single,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [2:0]        m_awprot,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [2:0]        m_arprot,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [31:0]       m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic              cpl_load,
  output logic [TAG_W-1:0]  cpl_ld_tag,
  output logic [2:0]        cpl_ld_status,
  output logic              cpl_ld_has_data,
  output logic [31:0]       cpl_ld_data,
  input  logic              cpl_done,
  output logic              err_cor,
  output logic              err_uncor
);
  import pxb_pkg::*;

  localparam logic [ADDR_W-1:0] ALIGN_MASK = ~ADDR_W'(3);

  ctrl_state_e        state_q, state_d;
  logic               aw_pend_q, aw_pend_d;
  logic               w_pend_q, w_pend_d;
  logic [ADDR_W-1:0]  addr_q, addr_d;
  logic [31:0]        data_q, data_d;
  logic [3:0]         be_q, be_d;
  logic [TAG_W-1:0]   tag_q, tag_d;
  logic               posted_q, posted_d;
  logic               cor_d, uncor_d;
  logic               accept;

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign m_awaddr  = addr_q;
  assign m_araddr  = addr_q;
  assign m_awprot  = PROT;
  assign m_arprot  = PROT;
  assign m_wdata   = data_q;
  assign m_wstrb   = be_q;
  assign m_awvalid = (state_q == ST_WRITE) && aw_pend_q;
  assign m_wvalid  = (state_q == ST_WRITE) && w_pend_q;
  assign m_bready  = (state_q == ST_BRESP);
  assign m_arvalid = (state_q == ST_RADDR);
  assign m_rready  = (state_q == ST_RDATA);

  always_comb begin
    state_d         = state_q;
    aw_pend_d       = aw_pend_q;
    w_pend_d        = w_pend_q;
    addr_d          = addr_q;
    data_d          = data_q;
    be_d            = be_q;
    tag_d           = tag_q;
    posted_d        = posted_q;
    cor_d           = 1'b0;
    uncor_d         = 1'b0;
    cpl_load        = 1'b0;
    cpl_ld_tag      = tag_q;
    cpl_ld_status   = CPL_SC;
    cpl_ld_has_data = 1'b0;
    cpl_ld_data     = '0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept) begin
          addr_d   = req_addr & ALIGN_MASK;
          data_d   = req_data;
          be_d     = req_be;
          tag_d    = req_tag;
          posted_d = dec_posted;
          if (!dec_single) begin
            if (dec_posted) begin
              uncor_d = 1'b1;
            end else begin
              cor_d         = 1'b1;
              cpl_load      = 1'b1;
              cpl_ld_tag    = req_tag;
              cpl_ld_status = CPL_CA;
              state_d       = ST_CPL;
            end
          end else if (dec_write) begin
            aw_pend_d = 1'b1;
            w_pend_d  = 1'b1;
            state_d   = ST_WRITE;
          end else begin
            state_d = ST_RADDR;
          end
        end
      end
      ST_WRITE: begin
        if (m_awready) aw_pend_d = 1'b0;
        if (m_wready)  w_pend_d  = 1'b0;
        if (!aw_pend_d && !w_pend_d) state_d = ST_BRESP;
      end
      ST_BRESP: begin
        if (m_bvalid) begin
          if (posted_q) begin
            state_d = ST_IDLE;
          end else begin
            cpl_load      = 1'b1;
            cpl_ld_status = (m_bresp == AXRESP_OKAY) ? CPL_SC : CPL_CA;
            state_d       = ST_CPL;
          end
        end
      end
      ST_RADDR: begin
        if (m_arready) state_d = ST_RDATA;
      end
      ST_RDATA: begin
        if (m_rvalid) begin
          cpl_load        = 1'b1;
          cpl_ld_status   = (m_rresp == AXRESP_OKAY) ? CPL_SC : CPL_CA;
          cpl_ld_has_data = 1'b1;
          cpl_ld_data     = m_rdata;
          state_d         = ST_CPL;
        end
      end
      ST_CPL: begin
        if (cpl_done) state_d = ST_IDLE;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_IDLE;
      aw_pend_q <= 1'b0;
      w_pend_q  <= 1'b0;
      err_cor   <= 1'b0;
      err_uncor <= 1'b0;
    end else begin
      state_q   <= state_d;
      aw_pend_q <= aw_pend_d;
      w_pend_q  <= w_pend_d;
      err_cor   <= cor_d;
      err_uncor <= uncor_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q   <= '0;
      data_q   <= '0;
      be_q     <= '0;
      tag_q    <= '0;
      posted_q <= 1'b0;
    end else if (accept) begin
      addr_q   <= addr_d;
      data_q   <= data_d;
      be_q     <= be_d;
      tag_q    <= tag_d;
      posted_q <= posted_d;
    end
  end

  assert_aw_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid && !m_awready) |=> (m_awvalid && $stable(m_awaddr)));
  assert_w_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (m_wvalid && !m_wready) |=> (m_wvalid && $stable(m_wdata) && $stable(m_wstrb)));
  assert_no_mixed_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !((m_awvalid || m_wvalid || m_bready) && (m_arvalid || m_rready)));
  assert_addr_aligned_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid || m_arvalid) |-> (m_awaddr[1:0] == 2'b00));
endmodule

// File: rtl/pcie_axil_bridge.sv
module pcie_axil_bridge #(
  parameter int         ADDR_W = 32,
  parameter int         LEN_W  = 11,
  parameter int         TAG_W  = 8,
  parameter logic [2:0] PROT   = 3'b010
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [15:0]       cfg_cid,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [1:0]        req_kind,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [3:0]        req_be,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic [31:0]       req_data,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [TAG_W-1:0]  cpl_tag,
  output logic [2:0]        cpl_status,
  output logic              cpl_has_data,
  output logic [31:0]       cpl_data,
  output logic [15:0]       cpl_cid,
  output logic [ADDR_W-1:0] m_awaddr,
  output logic [2:0]        m_awprot,
  output logic              m_awvalid,
  input  logic              m_awready,
  output logic [31:0]       m_wdata,
  output logic [3:0]        m_wstrb,
  output logic              m_wvalid,
  input  logic              m_wready,
  input  logic [1:0]        m_bresp,
  input  logic              m_bvalid,
  output logic              m_bready,
  output logic [ADDR_W-1:0] m_araddr,
  output logic [2:0]        m_arprot,
  output logic              m_arvalid,
  input  logic              m_arready,
  input  logic [31:0]       m_rdata,
  input  logic [1:0]        m_rresp,
  input  logic              m_rvalid,
  output logic              m_rready,
  output logic              err_cor,
  output logic              err_uncor
);
  import pxb_pkg::*;

  logic             dec_write, dec_posted, dec_single;
  logic             cpl_load, cpl_ld_has_data, cpl_done;
  logic [TAG_W-1:0] cpl_ld_tag;
  logic [2:0]       cpl_ld_status;
  logic [31:0]      cpl_ld_data;

  pxb_decode #(.LEN_W(LEN_W)) u_decode (
    .kind(req_kind), .len(req_len),
    .is_write(dec_write), .is_posted(dec_posted), .single_dw(dec_single)
  );

  pxb_ctrl #(.ADDR_W(ADDR_W), .TAG_W(TAG_W), .PROT(PROT)) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
    .req_be(req_be), .req_tag(req_tag), .req_data(req_data),
    .dec_write(dec_write), .dec_posted(dec_posted), .dec_single(dec_single),
    .m_awaddr(m_awaddr), .m_awprot(m_awprot), .m_awvalid(m_awvalid), .m_awready(m_awready),
    .m_wdata(m_wdata), .m_wstrb(m_wstrb), .m_wvalid(m_wvalid), .m_wready(m_wready),
    .m_bresp(m_bresp), .m_bvalid(m_bvalid), .m_bready(m_bready),
    .m_araddr(m_araddr), .m_arprot(m_arprot), .m_arvalid(m_arvalid), .m_arready(m_arready),
    .m_rdata(m_rdata), .m_rresp(m_rresp), .m_rvalid(m_rvalid), .m_rready(m_rready),
    .cpl_load(cpl_load), .cpl_ld_tag(cpl_ld_tag), .cpl_ld_status(cpl_ld_status),
    .cpl_ld_has_data(cpl_ld_has_data), .cpl_ld_data(cpl_ld_data), .cpl_done(cpl_done),
    .err_cor(err_cor), .err_uncor(err_uncor)
  );

  pxb_cpl_out #(.TAG_W(TAG_W)) u_cpl (
    .clk(clk), .rst_n(rst_n), .load(cpl_load),
    .ld_tag(cpl_ld_tag), .ld_status(cpl_ld_status), .ld_has_data(cpl_ld_has_data),
    .ld_data(cpl_ld_data), .cfg_cid(cfg_cid), .cpl_ready(cpl_ready),
    .cpl_valid(cpl_valid), .cpl_tag(cpl_tag), .cpl_status(cpl_status),
    .cpl_has_data(cpl_has_data), .cpl_data(cpl_data), .cpl_cid(cpl_cid),
    .cpl_done(cpl_done)
  );

  assert_one_inflight_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (m_awvalid || m_wvalid || m_arvalid || m_bready || m_rready || cpl_valid) |-> !req_ready);
  assert_uncor_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    err_uncor |-> (!m_awvalid && !m_arvalid && !cpl_valid && !err_cor));
  assert_cor_abort_R9: assert property (@(posedge clk) disable iff (!rst_n)
    err_cor |-> (cpl_valid && cpl_status == CPL_CA && !cpl_has_data));
endmodule

// File: tb/pcie_axil_bridge_bench.sv
module pcie_axil_bridge_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_cid = 16'h2468;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [1:0]  req_kind = '0;
  logic [31:0] req_addr = '0;
  logic [10:0] req_len = '0;
  logic [3:0]  req_be = '0;
  logic [7:0]  req_tag = '0;
  logic [31:0] req_data = '0;
  logic        cpl_valid, cpl_ready = 1'b0;
  logic [7:0]  cpl_tag;
  logic [2:0]  cpl_status;
  logic        cpl_has_data;
  logic [31:0] cpl_data;
  logic [15:0] cpl_cid;
  logic [31:0] m_awaddr, m_wdata, m_araddr;
  logic [2:0]  m_awprot, m_arprot;
  logic        m_awvalid, m_wvalid, m_bready, m_arvalid, m_rready;
  logic        m_awready = 0, m_wready = 0, m_bvalid = 0, m_arready = 0, m_rvalid = 0;
  logic [3:0]  m_wstrb;
  logic [1:0]  m_bresp = 0, m_rresp = 0;
  logic [31:0] m_rdata = 0;
  logic        err_cor, err_uncor;

  pcie_axil_bridge u_pcie_axil_bridge (.*);

  always #10 clk = ~clk;

  int n_chk = 0, n_err = 0;
  logic [31:0] mem [0:255];
  int aw_lat = 0, w_lat = 0, aw_cnt = 0, w_cnt = 0;
  bit aw_got, w_got, b_go, ar_got, r_go, slv_err;
  logic [31:0] aw_a, ar_a, w_d;
  logic [3:0]  w_s;
  int n_wr = 0, n_rd = 0, n_cor = 0, n_uncor = 0, n_cplv = 0;

  task automatic chk(input string rq, input string what, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
    end
  endtask

  // AXI-Lite target model, driven away from the active edge
  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 32'h0;
    forever begin
      @(negedge clk);
      if (err_cor) n_cor++;
      if (err_uncor) n_uncor++;
      if (cpl_valid) n_cplv++;
      if (m_awready) begin m_awready = 0; aw_got = 1; end
      if (m_wready) begin m_wready = 0; w_got = 1; end
      if (m_arready) begin m_arready = 0; ar_got = 1; end
      if (b_go) begin m_bvalid = 0; b_go = 0; end
      if (r_go) begin m_rvalid = 0; r_go = 0; end
      if (m_awvalid && !aw_got) begin
        if (aw_cnt >= aw_lat) begin m_awready = 1; aw_a = m_awaddr; end else aw_cnt++;
      end
      if (m_wvalid && !w_got) begin
        if (w_cnt >= w_lat) begin m_wready = 1; w_d = m_wdata; w_s = m_wstrb; end else w_cnt++;
      end
      if (aw_got && w_got && !m_bvalid) begin
        for (int b = 0; b < 4; b++)
          if (w_s[b]) mem[aw_a[9:2]][8*b +: 8] = w_d[8*b +: 8];
        n_wr++;
        m_bvalid = 1; m_bresp = slv_err ? 2'b10 : 2'b00;
        aw_got = 0; w_got = 0; aw_cnt = 0; w_cnt = 0;
      end
      if (m_bvalid && m_bready) b_go = 1;
      if (m_arvalid && !ar_got && !m_arready) begin m_arready = 1; ar_a = m_araddr; end
      if (ar_got && !m_rvalid) begin
        m_rdata = mem[ar_a[9:2]]; m_rresp = slv_err ? 2'b10 : 2'b00;
        m_rvalid = 1; ar_got = 0; n_rd++;
      end
      if (m_rvalid && m_rready) r_go = 1;
    end
  end

  task automatic send_req(input logic [1:0] kind, input logic [31:0] addr, input logic [10:0] len,
                          input logic [3:0] be, input logic [7:0] tag, input logic [31:0] data);
    @(negedge clk);
    req_kind = kind; req_addr = addr; req_len = len; req_be = be; req_tag = tag; req_data = data;
    req_valid = 1;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic recv_cpl(input string rq, input logic [7:0] tag, input logic [2:0] st,
                          input logic hd, input logic [31:0] data);
    logic [7:0] t0;
    for (int i = 0; i < 200 && !cpl_valid; i++) @(negedge clk);
    chk(rq, "completion present", cpl_valid, 1);
    chk("R6", "tag", cpl_tag, tag);
    chk("R6", "completer id", cpl_cid, cfg_cid);
    chk(rq, "status", cpl_status, st);
    chk(rq, "has data", cpl_has_data, hd);
    if (hd) chk(rq, "data", cpl_data, data);
    t0 = cpl_tag;
    chk("R10", "ready low while completion pending", req_ready, 0);
    idle(2);
    chk("R11", "valid held", cpl_valid, 1);
    chk("R11", "tag held", cpl_tag, t0);
    chk("R11", "status held", cpl_status, st);
    cpl_ready = 1;
    @(negedge clk);
    cpl_ready = 0;
    chk("R11", "valid drops after accept", cpl_valid, 0);
    chk("R10", "ready back", req_ready, 1);
  endtask

  task automatic t_reset;
    chk("R1", "req_ready", req_ready, 1);
    chk("R1", "cpl_valid", cpl_valid, 0);
    chk("R1", "valids", {m_awvalid, m_wvalid, m_arvalid}, 0);
    chk("R1", "strobes", {err_cor, err_uncor}, 0);
  endtask

  task automatic t_mem_write;
    int w0;
    mem[2] = 32'h0; w0 = n_wr; n_cplv = 0;
    send_req(2'd1, 32'h8, 11'd1, 4'hF, 8'h11, 32'h4433_2211);
    chk("R10", "ready low after accept", req_ready, 0);
    idle(15);
    chk("R2", "word written", mem[2], 32'h4433_2211);
    chk("R2", "one axi write", n_wr - w0, 1);
    chk("R2", "no completion", n_cplv, 0);
    chk("R2", "aw address", aw_a, 32'h8);
  endtask

  task automatic t_partial;
    logic [31:0] exp, dat;
    logic [3:0] be;
    int idx, mode;
    for (int len = 1; len <= 4; len++)
      for (int off = 0; off <= 4 - len; off++) begin
        idx = 16 + len * 4 + off;
        mode = (len + off) % 3;
        aw_lat = (mode == 1) ? 3 : 0;
        w_lat  = (mode == 2) ? 3 : 0;
        mem[idx] = 32'hAAAA_AAAA;
        be = 4'(((1 << len) - 1) << off);
        dat = 32'h1122_3344 ^ 32'(idx);
        exp = 32'hAAAA_AAAA;
        for (int b = 0; b < 4; b++) if (be[b]) exp[8*b +: 8] = dat[8*b +: 8];
        n_cplv = 0;
        send_req(2'd1, 32'(idx * 4 + off), 11'd1, be, 8'(idx), dat);
        idle(15);
        chk(mode == 0 ? "R2" : "R3", "partial write merge", mem[idx], exp);
        chk("R2", "aligned address", aw_a, 32'(idx * 4));
        chk("R2", "posted no completion", n_cplv, 0);
      end
    aw_lat = 0; w_lat = 0;
  endtask

  task automatic t_io_write;
    send_req(2'd3, 32'h40, 11'd1, 4'hF, 8'h5A, 32'hCAFE_F00D);
    recv_cpl("R4", 8'h5A, 3'd0, 1'b0, 32'h0);
    chk("R4", "io write landed", mem[16], 32'hCAFE_F00D);
  endtask

  task automatic t_reads;
    mem[7] = 32'hDEAD_BEEF;
    send_req(2'd0, 32'h1D, 11'd1, 4'h2, 8'h21, 32'h0);
    recv_cpl("R5", 8'h21, 3'd0, 1'b1, 32'hDEAD_BEEF);
    cfg_cid = 16'h0A05;
    send_req(2'd2, 32'h1C, 11'd1, 4'hF, 8'h22, 32'h0);
    recv_cpl("R5", 8'h22, 3'd0, 1'b1, 32'hDEAD_BEEF);
  endtask

  task automatic t_bad_write;
    int w0, r0, c0, u0;
    mem[0] = 32'h1234_5678; w0 = n_wr; r0 = n_rd; c0 = n_cor; u0 = n_uncor; n_cplv = 0;
    send_req(2'd1, 32'h0, 11'd16, 4'hF, 8'h30, 32'hFFFF_FFFF);
    chk("R10", "ready stays high after dropped write", req_ready, 1);
    idle(10);
    chk("R8", "no axi write", n_wr - w0, 0);
    chk("R8", "no axi read", n_rd - r0, 0);
    chk("R8", "memory untouched", mem[0], 32'h1234_5678);
    chk("R8", "uncor one pulse", n_uncor - u0, 1);
    chk("R8", "no cor", n_cor - c0, 0);
    chk("R8", "no completion", n_cplv, 0);
  endtask

  task automatic t_bad_read;
    int w0, r0, c0, u0;
    w0 = n_wr; r0 = n_rd; c0 = n_cor; u0 = n_uncor;
    send_req(2'd0, 32'h0, 11'd2, 4'hF, 8'h31, 32'h0);
    recv_cpl("R9", 8'h31, 3'd4, 1'b0, 32'h0);
    send_req(2'd3, 32'h0, 11'd0, 4'hF, 8'h32, 32'h0);
    recv_cpl("R9", 8'h32, 3'd4, 1'b0, 32'h0);
    idle(3);
    chk("R9", "no axi access", (n_wr - w0) + (n_rd - r0), 0);
    chk("R9", "cor pulses", n_cor - c0, 2);
    chk("R9", "no uncor", n_uncor - u0, 0);
  endtask

  task automatic t_slave_error;
    slv_err = 1;
    send_req(2'd0, 32'h10, 11'd1, 4'hF, 8'h40, 32'h0);
    recv_cpl("R7", 8'h40, 3'd4, 1'b1, mem[4]);
    send_req(2'd3, 32'h10, 11'd1, 4'hF, 8'h41, 32'h0);
    recv_cpl("R7", 8'h41, 3'd4, 1'b0, 32'h0);
    n_cplv = 0;
    send_req(2'd1, 32'h10, 11'd1, 4'hF, 8'h42, 32'h0);
    idle(12);
    chk("R7", "posted error gives no completion", n_cplv, 0);
    slv_err = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_err++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    idle(3);
    rst_n = 1;
    idle(2);
    t_reset();
    t_mem_write();
    t_partial();
    t_io_write();
    t_reads();
    t_bad_write();
    t_bad_read();
    t_slave_error();
    idle(5);
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule